// File: doc/BRIEF.md
# Palette Colour Table Host Port

This block holds a colour lookup table of 256 entries, each made of an 8-bit red, green and blue component. A host reaches the table through a byte-wide register bus with four addresses: a write-index register, a data register, a read-index register and one unused address. A host loads a palette by setting the write index once and then writing the data register repeatedly. The writes fill red, then green, then blue of one entry and then move on to the next entry. Reading the palette back works the same way through the read index.

One component counter is shared by data reads and data writes. Writing either index register clears that counter.

A second, independent port serves the display path. The display side presents an index with a request strobe, and one clock later the block returns all three components of that entry, with a valid flag. This port has no back-pressure: it accepts a request every cycle and its result is not held for a consumer. The host bus also has no wait states. A data read is answered combinationally in the same cycle as its strobe.

Top module: `pal_dac_port`

## Requirements
- R1: After reset, the write index and read index are 0 and the component counter is 0. Reading address 0 or address 2 returns 0.
- R2: A host write to address 0 loads the write index with the written byte and clears the component counter. The write index reads back at address 0.
- R3: A host write to address 2 loads the read index with the written byte and clears the component counter. The read index reads back at address 2.
- R4: A host write to address 1 stores the byte into one component of the entry at the write index: red when the counter is 0, green when it is 1, blue when it is 2. The write then advances the counter.
- R5: A host read of address 1 returns, in the same cycle as the strobe, the component selected by the counter from the entry at the read index. The read then advances the counter.
- R6: The data access made while the counter is 2 returns the counter to 0 and adds one to the index used by that access. Index 255 wraps to 0.
- R7: Data reads and data writes step the same counter. A read that follows one data write therefore returns the green component.
- R8: The display port is independent of the host port. A cycle with the lookup request high produces, on the next cycle, lookup valid high and the entry's colour packed as red in bits 23:16, green in bits 15:8 and blue in bits 7:0. A cycle with the request low gives valid low on the next cycle.
- R9: Address 3 reads as 0, and writes to address 3 change no index, no counter and no palette entry.
- R10: When the read and write strobes are high in the same cycle, only the write takes effect. The read causes no counter step and no index step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Host register address |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data (combinational) |
| lk_req | input | 1 | Display lookup request |
| lk_idx | input | 8 | Display lookup index |
| lk_vld | output | 1 | Display result valid, one cycle after request |
| lk_rgb | output | 24 | Display result {red, green, blue} |

## Verification
The situation that is hardest to reach from the ports is the index wrap from 255 to 0. The counter also has to reach that wrap with the correct phase, and nothing but a long run of data accesses can move an index past 255. The bench sets the write index to 0 and writes all 768 component bytes in one unbroken run. It then checks that the write index has come back to 0, and repeats the same full run through the read index. Mixed read and write sequences, started after an index write has cleared the counter, exercise the shared counter phase.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;
  typedef enum logic [1:0] {
    REG_WIDX = 2'd0,
    REG_DATA = 2'd1,
    REG_RIDX = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int NUM_COMP = 3;
  localparam logic [1:0] COMP_LAST = 2'd2;
endpackage

// File: rtl/pal_dac_seq.sv
module pal_dac_seq
  import pal_dac_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int DAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic [DAT_W-1:0] wdata,
  output logic [IDX_W-1:0] widx,
  output logic [IDX_W-1:0] ridx,
  output logic [1:0]       comp,
  output logic             data_we,
  output logic             data_re
);
  reg_sel_e sel;
  logic     idx_load;
  logic     step;
  logic     wrap;

  always_comb begin
    sel      = reg_sel_e'(addr);
    data_we  = wr_stb && (sel == REG_DATA);
    // write strobe takes precedence over a simultaneous read
    data_re  = rd_stb && !wr_stb && (sel == REG_DATA);
    idx_load = wr_stb && ((sel == REG_WIDX) || (sel == REG_RIDX));
    step     = data_we || data_re;
    wrap     = step && (comp == COMP_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp <= '0;
    end else if (idx_load) begin
      comp <= '0;
    end else if (wrap) begin
      comp <= '0;
    end else if (step) begin
      comp <= comp + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx <= '0;
    end else if (wr_stb && sel == REG_WIDX) begin
      widx <= wdata[IDX_W-1:0];
    end else if (wrap && data_we) begin
      widx <= widx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ridx <= '0;
    end else if (wr_stb && sel == REG_RIDX) begin
      ridx <= wdata[IDX_W-1:0];
    end else if (wrap && data_re) begin
      ridx <= ridx + 1'b1;
    end
  end
endmodule

// File: rtl/pal_dac_store.sv
module pal_dac_store
  import pal_dac_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int DAT_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [1:0]                comp,
  input  logic [IDX_W-1:0]          widx,
  input  logic [DAT_W-1:0]          wdata,
  input  logic [IDX_W-1:0]          ridx,
  output logic [DAT_W-1:0]          host_q,
  input  logic                      lk_req,
  input  logic [IDX_W-1:0]          lk_idx,
  output logic                      lk_vld,
  output logic [NUM_COMP*DAT_W-1:0] lk_rgb
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DAT_W-1:0] host_c [NUM_COMP];
  logic [DAT_W-1:0] disp_c [NUM_COMP];

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    logic [DAT_W-1:0] mem [DEPTH];
    logic             we_c;

    assign we_c = we && (comp == 2'(c));

    always_ff @(posedge clk) begin
      if (we_c) mem[widx] <= wdata;
    end

    always_ff @(posedge clk) begin
      if (lk_req) disp_c[c] <= mem[lk_idx];
    end

    assign host_c[c] = mem[ridx];
    // red occupies the most significant slice
    assign lk_rgb[(NUM_COMP-1-c)*DAT_W +: DAT_W] = disp_c[c];
  end

  always_comb begin
    case (comp)
      2'd0:    host_q = host_c[0];
      2'd1:    host_q = host_c[1];
      2'd2:    host_q = host_c[2];
      default: host_q = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lk_vld <= 1'b0;
    else        lk_vld <= lk_req;
  end
endmodule

// File: rtl/pal_dac_port.sv
module pal_dac_port
  import pal_dac_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int DAT_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                reg_addr,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [DAT_W-1:0]          reg_wdata,
  output logic [DAT_W-1:0]          reg_rdata,
  input  logic                      lk_req,
  input  logic [IDX_W-1:0]          lk_idx,
  output logic                      lk_vld,
  output logic [NUM_COMP*DAT_W-1:0] lk_rgb
);
  logic [IDX_W-1:0] widx;
  logic [IDX_W-1:0] ridx;
  logic [1:0]       comp;
  logic             data_we;
  logic             data_re;
  logic [DAT_W-1:0] host_q;

  pal_dac_seq #(.IDX_W(IDX_W), .DAT_W(DAT_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (reg_addr),
    .wr_stb  (reg_wr),
    .rd_stb  (reg_rd),
    .wdata   (reg_wdata),
    .widx    (widx),
    .ridx    (ridx),
    .comp    (comp),
    .data_we (data_we),
    .data_re (data_re)
  );

  pal_dac_store #(.IDX_W(IDX_W), .DAT_W(DAT_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (data_we),
    .comp   (comp),
    .widx   (widx),
    .wdata  (reg_wdata),
    .ridx   (ridx),
    .host_q (host_q),
    .lk_req (lk_req),
    .lk_idx (lk_idx),
    .lk_vld (lk_vld),
    .lk_rgb (lk_rgb)
  );

  always_comb begin
    case (reg_sel_e'(reg_addr))
      REG_WIDX: reg_rdata = DAT_W'(widx);
      REG_DATA: reg_rdata = host_q;
      REG_RIDX: reg_rdata = DAT_W'(ridx);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pal_dac_port_chk.sv
module pal_dac_port_chk #(
  parameter int IDX_W = 8,
  parameter int DAT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       reg_addr,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [DAT_W-1:0] reg_wdata,
  input logic             lk_req,
  input logic             lk_vld,
  input logic [IDX_W-1:0] widx,
  input logic [IDX_W-1:0] ridx,
  input logic [1:0]       comp
);
  // R6
  comp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comp != 2'd3);

  // R2
  widx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> (widx == $past(reg_wdata[IDX_W-1:0]) && comp == 2'd0));

  // R3
  ridx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2) |=> (ridx == $past(reg_wdata[IDX_W-1:0]) && comp == 2'd0));

  // R6
  widx_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && comp == 2'd2) |=> (widx == $past(widx) + 1'b1 && comp == 2'd0));

  // R10
  rd_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_rd && reg_addr == 2'd1) |=> ridx == $past(ridx));

  // R9
  dead_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3) |=> ($stable(widx) && $stable(ridx) && $stable(comp)));

  // R8
  lk_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_vld);
endmodule

bind pal_dac_port pal_dac_port_chk #(.IDX_W(IDX_W), .DAT_W(DAT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_wdata (reg_wdata),
  .lk_req    (lk_req),
  .lk_vld    (lk_vld),
  .widx      (widx),
  .ridx      (ridx),
  .comp      (comp)
);

// File: tb/pal_dac_port_bench.sv
`timescale 1ns/1ps
module pal_dac_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        lk_req = 1'b0;
  logic [7:0]  lk_idx = '0;
  logic        lk_vld;
  logic [23:0] lk_rgb;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pal_dac_port u_pal_dac_port (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_req(lk_req), .lk_idx(lk_idx), .lk_vld(lk_vld), .lk_rgb(lk_rgb)
  );

  function automatic logic [7:0] pat(int i, int c);
    return 8'((i * 7 + c * 85 + 3) & 255);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  initial begin
    #1_600_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    bus_rd(2'd0, v); check("R1 widx", v, 0);
    bus_rd(2'd2, v); check("R1 ridx", v, 0);
    @(negedge clk); check("R8 idle vld", lk_vld, 0);

    // R4 R6 full write sweep from index 0, wraps back to 0
    bus_wr(2'd0, 8'd0);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) bus_wr(2'd1, pat(i, c));
    bus_rd(2'd0, v); check("R6 widx wrap", v, 0);

    // R5 R6 full read sweep
    bus_wr(2'd2, 8'd0);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) begin
        bus_rd(2'd1, v); check("R5 data read", v, pat(i, c));
      end
    bus_rd(2'd2, v); check("R6 ridx wrap", v, 0);

    // R8 display sweep
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); lk_req = 1'b1; lk_idx = 8'(i);
      @(posedge clk); #1; lk_req = 1'b0;
      check("R8 lk_vld", lk_vld, 1);
      check("R8 lk_rgb", lk_rgb, {pat(i, 0), pat(i, 1), pat(i, 2)});
    end
    @(posedge clk); #1; check("R8 vld drop", lk_vld, 0);

    // R2 R3 index load and readback, mid-counter clear
    bus_wr(2'd0, 8'd200); bus_rd(2'd0, v); check("R2 widx load", v, 200);
    bus_wr(2'd2, 8'd77);  bus_rd(2'd2, v); check("R3 ridx load", v, 77);
    bus_rd(2'd1, v); check("R5 R of 77", v, pat(77, 0));
    bus_wr(2'd2, 8'd77);  // clears counter
    bus_rd(2'd1, v); check("R3 counter cleared", v, pat(77, 0));

    // R7 shared counter: write one then read
    bus_wr(2'd2, 8'd10);
    bus_wr(2'd0, 8'd5);
    bus_wr(2'd1, 8'hAA);
    bus_rd(2'd1, v); check("R7 green after write", v, pat(10, 1));
    bus_rd(2'd1, v); check("R7 blue", v, pat(10, 2));
    bus_rd(2'd2, v); check("R7 ridx advanced", v, 11);
    bus_rd(2'd0, v); check("R7 widx kept", v, 5);
    @(negedge clk); lk_req = 1'b1; lk_idx = 8'd5;
    @(posedge clk); #1; lk_req = 1'b0;
    check("R4 red stored", lk_rgb, {8'hAA, pat(5, 1), pat(5, 2)});

    // R9 dead address
    bus_wr(2'd3, 8'h5A);
    bus_rd(2'd3, v); check("R9 reads zero", v, 0);
    bus_rd(2'd0, v); check("R9 widx kept", v, 5);
    bus_rd(2'd2, v); check("R9 ridx kept", v, 11);

    // R10 simultaneous strobes: write wins, read does nothing
    bus_wr(2'd2, 8'd30);
    bus_wr(2'd0, 8'd30);
    @(negedge clk);
    reg_addr = 2'd1; reg_wdata = 8'h11; reg_wr = 1'b1; reg_rd = 1'b1;
    @(posedge clk); #1; reg_wr = 1'b0; reg_rd = 1'b0;
    bus_rd(2'd1, v); check("R10 counter stepped once", v, pat(30, 1));
    bus_rd(2'd1, v); check("R10 blue", v, pat(30, 2));
    bus_rd(2'd2, v); check("R10 ridx", v, 31);
    @(negedge clk); lk_req = 1'b1; lk_idx = 8'd30;
    @(posedge clk); #1; lk_req = 1'b0;
    check("R10 write landed", lk_rgb, {8'h11, pat(30, 1), pat(30, 2)});

    // R6 write advance across 255
    bus_wr(2'd0, 8'd255);
    bus_wr(2'd1, 8'h01); bus_wr(2'd1, 8'h02); bus_wr(2'd1, 8'h03);
    bus_rd(2'd0, v); check("R6 255 wrap", v, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule